// File: doc/BRIEF.md
# Quad DAC serial command transmitter

This block turns a parallel write request into the three-wire serial sequence that a quad 8-bit DAC expects. A request carries a 2-bit channel number, a gain flag and an 8-bit code, and it is taken on a valid/ready handshake. The block builds an 11-bit frame and shifts it out on a serial clock and data pair, most significant bit first. It then drives the frame-latch strobe low for one bit period, so the DAC commits the frame to the selected channel.

A second strobe moves the latched codes to the analog outputs. It is pulsed either by an explicit update request or, in auto-update mode, right after every frame-latch pulse. A runtime divider input sets how many system cycles each half of a serial bit lasts. The block accepts one request at a time.

Top module: `qdac_cmd_tx`

## Requirements
- R1: The frame is sent MSB first as {chan[1:0], gain, value[7:0]}: frame bit 10 is chan[1], bit 9 is chan[0], bit 8 is the gain bit, and bits 7..0 are value[7:0].
- R2: A gain request of x2 (`req_gain_i`=1) is sent as a 1 in frame bit 8. A gain request of x1 (`req_gain_i`=0) is sent as a 0.
- R3: Each accepted request makes exactly 11 falling edges on `sclk_o`. `load_no` falls in the same cycle as the 11th falling edge.
- R4: `sdata_o` never changes in a cycle where `sclk_o` is high. This also holds for the cycle in which `sclk_o` rises.
- R5: `sclk_o` is low when idle. Every low phase and every high phase of a bit lasts div_i+1 system cycles.
- R6: `load_no` is high when idle. After a frame it stays low for 2*(div_i+1) cycles.
- R7: `req_ready_o` drops in the cycle after acceptance. It stays low until `load_no` returns high, which is 24*(div_i+1) cycles in total.
- R8: With `auto_upd_i`=1, `ldac_no` falls in the same cycle that `load_no` rises. It then stays low for 2*(div_i+1) cycles.
- R9: With `auto_upd_i`=0, a frame produces no `ldac_no` pulse. A one-cycle `upd_req_i` makes `ldac_no` go low in the next cycle, and it stays low for 2*(div_i+1) cycles.
- R10: An `upd_req_i` that arrives while an `ldac_no` pulse is in progress is ignored. The pulse keeps its length and no second pulse follows.
- R11: After reset, `req_ready_o`=1, `sclk_o`=0, `load_no`=1 and `ldac_no`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div_i | input | DIV_W | Phase length minus one, in system cycles; hold stable while busy |
| auto_upd_i | input | 1 | Pulse the output-update strobe after every frame |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block idle, ready to take a request |
| req_chan_i | input | CHAN_W | Target channel |
| req_gain_i | input | 1 | 1 selects x2 gain, 0 selects x1 |
| req_value_i | input | VAL_W | DAC code |
| upd_req_i | input | 1 | One-cycle request for an output-update pulse |
| sclk_o | output | 1 | Serial bit clock, idles low |
| sdata_o | output | 1 | Serial data, captured by the DAC on falling `sclk_o` |
| load_no | output | 1 | Frame-latch strobe, active low |
| ldac_no | output | 1 | Output-update strobe, active low |

## Verification
Let P = div_i+1. Counted from the acceptance edge, the first data bit and the ready drop appear at once. The 11th clock fall and the latch fall both come 22P cycles later, and ready returns 24P cycles after acceptance, together with the latch rise and any auto-update fall. A manual update pulse starts one cycle after the request is sampled. The bench samples every output on the falling system-clock edge, one sample per cycle. It measures the length of each phase and strobe by counting samples, and it compares those counts with the P-based values above; it does not wait for fixed delays. Each frame is checked at divider settings 0, 1 and 3.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_LO   = 2'd1,
    S_HI   = 2'd2,
    S_LOAD = 2'd3
  } tx_state_e;
endpackage

// File: rtl/qdac_phase_timer.sv
module qdac_phase_timer #(
  parameter int unsigned CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] len_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= len_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // R5
  timer_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/qdac_frame_shifter.sv
module qdac_frame_shifter #(
  parameter int unsigned FRAME_W = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               shift_i,
  output logic               data_o,
  output logic               last_o
);
  localparam int unsigned IDX_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sreg_q;
  logic [IDX_W-1:0]   idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      sreg_q <= frame_i;
      idx_q  <= '0;
    end else if (shift_i) begin
      sreg_q <= {sreg_q[FRAME_W-2:0], 1'b0};
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign data_o = sreg_q[FRAME_W-1];
  assign last_o = (idx_q == IDX_W'(FRAME_W - 1));

  // R3
  shift_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> !last_o);
endmodule

// File: rtl/qdac_ldac_pulser.sv
module qdac_ldac_pulser #(
  parameter int unsigned CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_i,
  input  logic [CW-1:0] len_i,
  output logic          ldac_no
);
  logic active_q;
  logic start;
  logic done;

  assign start = trig_i && !active_q;

  qdac_phase_timer #(.CW(CW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .len_i   (len_i),
    .done_o  (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 active_q <= 1'b0;
    else if (start)              active_q <= 1'b1;
    else if (active_q && done)   active_q <= 1'b0;
  end

  assign ldac_no = !active_q;

  // R10
  ldac_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ldac_no && !done) |=> !ldac_no);
endmodule

// File: rtl/qdac_cmd_tx.sv
module qdac_cmd_tx
  import qdac_pkg::*;
#(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned CHAN_W = 2,
  parameter int unsigned VAL_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              auto_upd_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [CHAN_W-1:0] req_chan_i,
  input  logic              req_gain_i,
  input  logic [VAL_W-1:0]  req_value_i,
  input  logic              upd_req_i,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              load_no,
  output logic              ldac_no
);
  localparam int unsigned FRAME_W = CHAN_W + 1 + VAL_W;
  localparam int unsigned CW      = DIV_W + 2;

  tx_state_e state_q, state_d;
  logic      sclk_q, load_nq;
  logic      t_start, t_done;
  logic [CW-1:0] t_len;
  logic      sh_load, sh_shift, sh_last;
  logic      auto_trig;

  logic [CW-1:0] len_phase, len_bit;
  assign len_phase = {2'b00, div_i};
  assign len_bit   = {1'b0, div_i, 1'b1};  // 2*(div+1)-1

  always_comb begin
    state_d   = state_q;
    t_start   = 1'b0;
    t_len     = len_phase;
    sh_load   = 1'b0;
    sh_shift  = 1'b0;
    auto_trig = 1'b0;
    unique case (state_q)
      S_IDLE: if (req_valid_i) begin
        state_d = S_LO;
        t_start = 1'b1;
        sh_load = 1'b1;
      end
      S_LO: if (t_done) begin
        state_d = S_HI;
        t_start = 1'b1;
      end
      S_HI: if (t_done) begin
        t_start = 1'b1;
        if (sh_last) begin
          state_d = S_LOAD;
          t_len   = len_bit;
        end else begin
          state_d  = S_LO;
          sh_shift = 1'b1;
        end
      end
      S_LOAD: if (t_done) begin
        state_d   = S_IDLE;
        auto_trig = auto_upd_i;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      sclk_q  <= 1'b0;
      load_nq <= 1'b1;
    end else begin
      state_q <= state_d;
      sclk_q  <= (state_d == S_HI);
      load_nq <= (state_d != S_LOAD);
    end
  end

  qdac_phase_timer #(.CW(CW)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (t_start),
    .len_i   (t_len),
    .done_o  (t_done)
  );

  qdac_frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (sh_load),
    .frame_i ({req_chan_i, req_gain_i, req_value_i}),
    .shift_i (sh_shift),
    .data_o  (sdata_o),
    .last_o  (sh_last)
  );

  qdac_ldac_pulser #(.CW(CW)) u_ldac (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (upd_req_i || auto_trig),
    .len_i   (len_bit),
    .ldac_no (ldac_no)
  );

  assign sclk_o      = sclk_q;
  assign load_no     = load_nq;
  assign req_ready_o = (state_q == S_IDLE);

  // R4
  data_stable_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(sdata_o));

  // R3
  load_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(load_no) |-> $past(sh_last));

  // R7
  busy_during_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_no |-> !req_ready_o);

  // R5
  idle_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!sclk_o && load_no));

  // R8
  auto_ldac_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(load_no) && $past(auto_upd_i)) |-> !ldac_no);
endmodule

// File: tb/tb_qdac_cmd_tx.sv
`timescale 1ns/1ps
module tb_qdac_cmd_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div = 8'd0;
  logic       auto_upd = 1'b0;
  logic       valid = 1'b0;
  logic       ready;
  logic [1:0] chan = '0;
  logic       gain = 1'b0;
  logic [7:0] value = '0;
  logic       upd = 1'b0;
  logic       sclk, sdata, load_n, ldac_n;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  qdac_cmd_tx dut (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .auto_upd_i(auto_upd),
    .req_valid_i(valid), .req_ready_o(ready), .req_chan_i(chan),
    .req_gain_i(gain), .req_value_i(value), .upd_req_i(upd),
    .sclk_o(sclk), .sdata_o(sdata), .load_no(load_n), .ldac_no(ldac_n)
  );

  // monitor: one sample per system cycle
  logic        p_sclk = 1'b0, p_data = 1'b0, p_load = 1'b1, p_ldac = 1'b1, p_rdy = 1'b1;
  logic [31:0] cap = '0;
  int falls = 0, viol = 0, hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0;
  int load_run = 0, last_load = 0, falls_at_load = 0;
  int ldac_run = 0, last_ldac = 0, ldac_pulses = 0, ldac_sync = 0;
  int busy_run = 0, last_busy = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk && sdata != p_data) viol++;
      if (p_sclk && !sclk) begin
        cap = {cap[30:0], p_data};
        falls++;
        last_hi = hi_run; hi_run = 0; lo_run = 0;
      end
      if (!p_sclk && sclk && falls > 0) last_lo = lo_run;
      if (sclk) hi_run++; else lo_run++;
      if (p_load && !load_n) falls_at_load = falls;
      if (!load_n) load_run++;
      if (!p_load && load_n) begin last_load = load_run; load_run = 0; end
      if (p_ldac && !ldac_n && !p_load && load_n) ldac_sync++;
      if (!ldac_n) ldac_run++;
      if (!p_ldac && ldac_n) begin last_ldac = ldac_run; ldac_run = 0; ldac_pulses++; end
      if (!ready) busy_run++;
      if (!p_rdy && ready) begin last_busy = busy_run; busy_run = 0; end
    end
    p_sclk = sclk; p_data = sdata; p_load = load_n; p_ldac = ldac_n; p_rdy = ready;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 ready", int'(ready), 1);
    chk("R11 sclk", int'(sclk), 0);
    chk("R11 load", int'(load_n), 1);
    chk("R11 ldac", int'(ldac_n), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_frame(input logic [1:0] c, input logic g, input logic [7:0] v,
                         input logic [7:0] d, input logic a);
    int f0, v0, l0, s0, p;
    p = int'(d) + 1;
    @(negedge clk);
    div = d; auto_upd = a;
    @(negedge clk);
    f0 = falls; v0 = viol; l0 = ldac_pulses; s0 = ldac_sync;
    chan = c; gain = g; value = v; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    chk("R7 ready drops", int'(ready), 0);
    while (!ready) @(negedge clk);
    repeat (2 * p + 4) @(negedge clk);
    chk("R1 frame bits", int'(cap[10:0]), int'({c, g, v}));
    chk("R2 gain bit", int'(cap[8]), int'(g));
    chk("R3 fall count", falls - f0, 11);
    chk("R3 load at 11th fall", falls_at_load - f0, 11);
    chk("R4 data stable", viol - v0, 0);
    chk("R5 high phase", last_hi, p);
    chk("R5 low phase", last_lo, p);
    chk("R6 load width", last_load, 2 * p);
    chk("R7 busy length", last_busy, 24 * p);
    if (a) begin
      chk("R8 auto ldac count", ldac_pulses - l0, 1);
      chk("R8 ldac with load rise", ldac_sync - s0, 1);
      chk("R8 ldac width", last_ldac, 2 * p);
    end else begin
      chk("R9 no ldac without auto", ldac_pulses - l0, 0);
    end
  endtask

  task automatic t_manual_upd(input logic [7:0] d);
    int l0, p;
    p = int'(d) + 1;
    @(negedge clk);
    div = d; auto_upd = 1'b0;
    @(negedge clk);
    l0 = ldac_pulses;
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    chk("R9 ldac low next cycle", int'(ldac_n), 0);
    repeat (2 * p + 3) @(negedge clk);
    chk("R9 manual ldac count", ldac_pulses - l0, 1);
    chk("R9 manual ldac width", last_ldac, 2 * p);
  endtask

  task automatic t_upd_ignored(input logic [7:0] d);
    int l0, p;
    p = int'(d) + 1;
    @(negedge clk);
    div = d;
    @(negedge clk);
    l0 = ldac_pulses;
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    repeat (2) @(negedge clk);
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    repeat (4 * p + 4) @(negedge clk);
    chk("R10 single pulse", ldac_pulses - l0, 1);
    chk("R10 pulse width", last_ldac, 2 * p);
  endtask

  initial begin
    t_reset();
    t_frame(2'b10, 1'b1, 8'hA5, 8'd0, 1'b0);
    t_frame(2'b01, 1'b0, 8'h3C, 8'd3, 1'b0);
    t_frame(2'b11, 1'b1, 8'hFF, 8'd1, 1'b1);
    t_frame(2'b00, 1'b0, 8'h00, 8'd3, 1'b1);
    t_manual_upd(8'd2);
    t_upd_ignored(8'd3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule